// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This block decides whether a card is allowed to run. A reset request of either kind, an addressed device-clear command or a reset assertion, starts a fixed run of six hardware sub-tests. While the run is in progress the card is held offline. The sub-tests are started one at a time, and each one answers with a done/pass handshake. The sequencer waits for each answer under a watchdog, moves to the next test when the answer is good, and stops at the first bad answer or timeout.

If all six sub-tests pass, the functional enable rises and stays high. If any sub-test fails, the card stays disabled and a failure flag is latched. The failure flag comes with the index of the failing test and a bit that says whether the failure was a timeout. For the serial loop-back test, an output selects whether the external line drivers take part in the test. It is set only when a loop-back hood was sensed.

Top module: `selftest_seq`

## Requirements
- R1: While reset is asserted and after it is released, before any request arrives, `func_en`, `st_busy`, `st_failed`, `fail_timeout`, `loop_ext_en`, `test_start` and `fail_idx` are all zero.
- R2: A one-cycle pulse on either `dev_clear_req` or `reset_assert_req` starts a run. In the next cycle `test_start` equals 6'b000001 for exactly one cycle and `st_busy` is high.
- R3: `func_en` stays low for every cycle in which a sub-test is being started or awaited.
- R4: Sub-tests are started in this fixed order of `test_start` bit positions: 0 ROM check, 1 RAM check, 2 serial loop-back, 3 counter/timer check, 4 backplane interface check, 5 memory interface check. When the current test's `test_done` bit is sampled high with its `test_pass` bit high, the next test's single start bit is asserted in the following cycle.
- R5: When test 5 passes, `func_en` is high from the next cycle and `st_busy` falls. `func_en` then holds until a new request.
- R6: When the current test's `test_done` bit is sampled high with `test_pass` low, the run stops. From the next cycle `st_failed` is high, `fail_idx` holds the test's bit position, `fail_timeout` is 0, `func_en` is low, and no further start is issued.
- R7: If the current test gives no done within `TIMEOUT_CYC` cycles after its start cycle, the run fails. `st_failed` rises `TIMEOUT_CYC`+1 cycles after the start pulse, `fail_idx` holds the test's position and `fail_timeout` is 1.
- R8: `loop_ext_en` equals the value of `hood_sensed` sampled at the edge that completes test 1. It holds that value during the start and waiting cycles of test 2 only, and is 0 at all other times.
- R9: A new request in any state, including mid-run, passed or failed, restarts the run from test 0 in the next cycle. It clears `st_failed`, `fail_timeout`, `fail_idx` and `func_en`.
- R10: `test_done`/`test_pass` bits of any test other than the one being awaited are ignored. The run neither advances nor fails on them.
- R11: After a failure, `st_failed`, `fail_idx` and `fail_timeout` hold their values until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_clear_req | input | 1 | Device-clear reset request pulse |
| reset_assert_req | input | 1 | Reset-assertion request pulse |
| hood_sensed | input | 1 | Loop-back hood present |
| test_done | input | 6 | Per-test completion strobe |
| test_pass | input | 6 | Per-test result, valid with done |
| test_start | output | 6 | One-cycle per-test start pulse |
| loop_ext_en | output | 1 | Use external line drivers in loop-back test |
| func_en | output | 1 | Normal operation enabled |
| st_busy | output | 1 | Self-test in progress |
| st_failed | output | 1 | Self-test failed; card disabled |
| fail_idx | output | 3 | Position of failing test |
| fail_timeout | output | 1 | Failure was a watchdog timeout |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 20 rather than its large default. This makes a watchdog expiry at any of the six positions reachable within a few dozen cycles, and it lets the exact expiry cycle be checked. Sub-test responders answer with varying delays, so the run can be forced to fail by result or by silence at chosen positions, with the hood both present and absent. Directed cases then cover stray strobes from other tests, restarts in the middle of a run and after a failure, and how long the pass and fail states hold.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    localparam int NUM_TESTS = 6;
    localparam int IDX_W     = 3;
    localparam int LOOP_IDX  = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_WAIT,
        S_READY,
        S_FAIL
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             hood;
        logic [IDX_W-1:0] fidx;
        logic             ftmo;
    } seq_regs_t;

endpackage

// File: rtl/selftest_wdog.sv
module selftest_wdog #(
    parameter int TIMEOUT_CYC = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/selftest_start_dec.sv
module selftest_start_dec #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic             valid,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign onehot[g] = valid && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int TIMEOUT_CYC = 65536
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dev_clear_req,
    input  logic                 reset_assert_req,
    input  logic                 hood_sensed,
    input  logic [NUM_TESTS-1:0] test_done,
    input  logic [NUM_TESTS-1:0] test_pass,
    output logic [NUM_TESTS-1:0] test_start,
    output logic                 loop_ext_en,
    output logic                 func_en,
    output logic                 st_busy,
    output logic                 st_failed,
    output logic [IDX_W-1:0]     fail_idx,
    output logic                 fail_timeout
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TESTS - 1);
    localparam logic [IDX_W-1:0] LOOP_I   = IDX_W'(LOOP_IDX);

    seq_regs_t r_d, r_q;
    logic      req;
    logic      cur_done;
    logic      cur_pass;
    logic      wd_expired;

    assign req      = dev_clear_req | reset_assert_req;
    assign cur_done = test_done[r_q.idx];
    assign cur_pass = test_pass[r_q.idx];

    selftest_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == S_WAIT),
        .expired (wd_expired)
    );

    selftest_start_dec #(.N(NUM_TESTS), .IDX_W(IDX_W)) i_dec (
        .valid  (r_q.st == S_LAUNCH),
        .idx    (r_q.idx),
        .onehot (test_start)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_LAUNCH: r_d.st = S_WAIT;
            S_WAIT: begin
                if (cur_done) begin
                    if (cur_pass) begin
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st = S_READY;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                            r_d.st  = S_LAUNCH;
                            if (r_q.idx + 1'b1 == LOOP_I) r_d.hood = hood_sensed;
                        end
                    end else begin
                        r_d.st   = S_FAIL;
                        r_d.fidx = r_q.idx;
                        r_d.ftmo = 1'b0;
                    end
                end else if (wd_expired) begin
                    r_d.st   = S_FAIL;
                    r_d.fidx = r_q.idx;
                    r_d.ftmo = 1'b1;
                end
            end
            default: ;
        endcase
        if (req) begin
            r_d.st   = S_LAUNCH;
            r_d.idx  = '0;
            r_d.hood = 1'b0;
            r_d.fidx = '0;
            r_d.ftmo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= S_IDLE;
            r_q.idx  <= '0;
            r_q.hood <= 1'b0;
            r_q.fidx <= '0;
            r_q.ftmo <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_busy      = (r_q.st == S_LAUNCH) || (r_q.st == S_WAIT);
    assign func_en      = (r_q.st == S_READY);
    assign st_failed    = (r_q.st == S_FAIL);
    assign fail_idx     = r_q.fidx;
    assign fail_timeout = r_q.ftmo;
    assign loop_ext_en  = r_q.hood && st_busy && (r_q.idx == LOOP_I);

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(test_start)); // R4
    AST_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (|test_start) |-> !func_en); // R3
    AST_REQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (test_start == NUM_TESTS'(1))); // R9
    AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (func_en && !req) |=> func_en); // R5
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_failed && !req) |=> (st_failed && $stable(fail_idx) && $stable(fail_timeout))); // R11
    AST_TIMEOUT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expired && !cur_done && !req) |=> (st_failed && fail_timeout)); // R7
    AST_NO_START_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        st_failed |-> (test_start == '0)); // R6

endmodule

// File: tb/test_selftest_seq.sv
module test_selftest_seq;
    localparam int T  = 20;
    localparam int NT = 6;

    typedef struct packed {
        logic       use_res;
        logic       hood;
        logic [2:0] fail_at;
        logic       tmo;
        logic       exp_func;
        logic       exp_fail;
        logic [2:0] exp_idx;
        logic       exp_tmo;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 3'd7, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0},
        '{1'b1, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0},
        '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0},
        '{1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0},
        '{1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1},
        '{1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b1, 3'd3, 1'b1},
        '{1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0},
        '{1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1, 3'd1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dev_clear_req = 1'b0;
    logic          reset_assert_req = 1'b0;
    logic          hood_sensed = 1'b0;
    logic [NT-1:0] test_done = '0;
    logic [NT-1:0] test_pass = '0;
    logic [NT-1:0] test_start;
    logic          loop_ext_en, func_en, st_busy, st_failed, fail_timeout;
    logic [2:0]    fail_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    selftest_seq #(.TIMEOUT_CYC(T)) i_selftest_seq (
        .clk(clk), .rst_n(rst_n),
        .dev_clear_req(dev_clear_req), .reset_assert_req(reset_assert_req),
        .hood_sensed(hood_sensed), .test_done(test_done), .test_pass(test_pass),
        .test_start(test_start), .loop_ext_en(loop_ext_en), .func_en(func_en),
        .st_busy(st_busy), .st_failed(st_failed), .fail_idx(fail_idx),
        .fail_timeout(fail_timeout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic use_res);
        @(negedge clk);
        if (use_res) reset_assert_req = 1'b1;
        else         dev_clear_req    = 1'b1;
        @(negedge clk);
        reset_assert_req = 1'b0;
        dev_clear_req    = 1'b0;
    endtask

    task automatic answer(input int t, input logic ok);
        test_done[t] = 1'b1;
        test_pass[t] = ok;
        @(negedge clk);
        test_done = '0;
        test_pass = '0;
    endtask

    task automatic run_vec(input vec_t v);
        hood_sensed = v.hood;
        pulse_req(v.use_res);
        chk("R2 busy after request", 32'(st_busy), 32'd1);
        for (int t = 0; t < NT; t++) begin
            chk("R4 start order", 32'(test_start), 32'(1 << t));
            chk("R8 external drivers", 32'(loop_ext_en), (t == 2) ? 32'(v.hood) : 32'd0);
            chk("R3 offline while testing", 32'(func_en), 32'd0);
            if (t == int'(v.fail_at) && v.tmo) begin
                int k = 0;
                do begin
                    @(negedge clk);
                    k++;
                end while (!st_failed && k < T + 5);
                chk("R7 timeout cycle", 32'(k), 32'(T + 1));
                break;
            end
            repeat (1 + t % 3) @(negedge clk);
            answer(t, t != int'(v.fail_at));
            if (t == int'(v.fail_at)) break;
        end
        chk("R5 R6 func_en", 32'(func_en), 32'(v.exp_func));
        chk("R6 failed flag", 32'(st_failed), 32'(v.exp_fail));
        chk("R6 R7 fail index", 32'(fail_idx), 32'(v.exp_idx));
        chk("R6 R7 timeout flag", 32'(fail_timeout), 32'(v.exp_tmo));
        chk("R5 R6 busy low", 32'(st_busy), 32'd0);
        repeat (3) @(negedge clk);
        chk("R6 no further start", 32'(test_start), 32'd0);
        chk("R8 ext low after run", 32'(loop_ext_en), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset func_en", 32'(func_en), 32'd0);
        chk("R1 reset busy", 32'(st_busy), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle start", 32'(test_start), 32'd0);
        chk("R1 idle failed", 32'(st_failed), 32'd0);
        chk("R1 idle func_en", 32'(func_en), 32'd0);
        chk("R1 idle fail_idx", 32'(fail_idx), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R5: pass state holds
        run_vec(VECS[0]);
        repeat (25) @(negedge clk);
        chk("R5 func_en held", 32'(func_en), 32'd1);

        // R10: stray strobes of other tests are ignored
        pulse_req(1'b0);
        chk("R9 restart from pass", 32'(func_en), 32'd0);
        @(negedge clk);
        answer(3, 1'b1);
        answer(1, 1'b0);
        repeat (2) @(negedge clk);
        chk("R10 still busy", 32'(st_busy), 32'd1);
        chk("R10 not failed", 32'(st_failed), 32'd0);
        chk("R10 no advance", 32'(test_start), 32'd0);
        answer(0, 1'b1);
        chk("R10 real answer advances", 32'(test_start), 32'b000010);

        // R9: restart mid-run
        pulse_req(1'b1);
        chk("R9 mid-run restart", 32'(test_start), 32'b000001);
        begin
            int k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!st_failed && k < T + 5);
            chk("R7 timeout at test 0", 32'(k), 32'(T + 1));
        end
        chk("R7 index", 32'(fail_idx), 32'd0);
        chk("R7 flag", 32'(fail_timeout), 32'd1);
        repeat (30) @(negedge clk);
        chk("R11 failed held", 32'(st_failed), 32'd1);
        chk("R11 timeout held", 32'(fail_timeout), 32'd1);
        chk("R11 no start", 32'(test_start), 32'd0);

        pulse_req(1'b0);
        chk("R9 clears failed", 32'(st_failed), 32'd0);
        chk("R9 clears timeout", 32'(fail_timeout), 32'd0);
        chk("R9 busy again", 32'(st_busy), 32'd1);
        chk("R9 start 0", 32'(test_start), 32'b000001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule